// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block turns a single command word, written by software with a one-cycle strobe, into the pin-level command sequence that brings one or two SDRAM devices out of power-up and places them in, or takes them out of, self-refresh. It drives chip selects, row and column strobes, write enable, the address bus, the bank select and clock enable. All of these are registered. It supports these operations:

- a plain no-op;
- raising clock enable;
- precharge-all;
- a burst of auto-refresh commands;
- a mode-register load;
- self-refresh entry.

After some commands it holds a minimum gap before any further command is accepted. The gap after a mode-register load and the gap after a self-refresh exit come from separate 4-bit inputs, each meaning code+1 clock cycles. A fixed parameter sets the spacing between consecutive refreshes. A busy output stays high from the first command cycle until the last gap cycle. Two sticky flags report rejected commands and commands written while busy. Software clears each flag by writing 0 to it.

Command word layout:

| Bits | Field |
|------|-------|
| 2:0 | operation code |
| 3 | select for device 0 |
| 4 | select for device 1 |
| 8:5 | refresh count |
| 21:9 | mode-register content |
| 31:22 | ignored |

Top module: `sdram_init_seq`

## Requirements
- R1: After synchronous reset, every chip select is high, RAS_n, CAS_n and WE_n are high, the address is 0, clock enable is low, and busy and both flags are low.
- R2: Code 3'b010 drives one precharge-all cycle: RAS_n low, CAS_n high, WE_n low, address bit 10 high and all other address bits low. Busy is high for that one cycle only.
- R3: Code 3'b001 raises clock enable in the same cycle as a single NOP (RAS_n, CAS_n and WE_n all high). Code 3'b000 drives a single NOP and leaves clock enable unchanged.
- R4: Code 3'b011 with count field c (0 to 14) issues c+1 auto-refresh commands (RAS_n low, CAS_n low, WE_n high). Each refresh is followed by RFC_GAP NOP cycles, and busy is high for (c+1)*(1+RFC_GAP) cycles.
- R5: Code 3'b011 with count field 4'hF issues no command, leaves busy low and sets the error flag.
- R6: Code 3'b100 drives one load-mode cycle (RAS_n, CAS_n and WE_n all low) with command-word bits 21:9 on the address and bank select 0. It then drives code+1 NOP cycles, where the code is lmr_gap sampled at the write.
- R7: Code 3'b101 drives an auto-refresh pattern and drops clock enable in the same cycle. The next code 3'b001 raises clock enable with a NOP and then holds srx_gap+1 further NOP cycles while busy.
- R8: Command-word bit 3 selects device 0 (chip-select bit 0) and bit 4 selects device 1. A selected device sees its chip select low on every busy cycle. An unselected device sees its chip select high for the whole sequence.
- R9: Busy rises in the first command cycle and falls in the cycle after the last gap cycle. While busy is low, all chip selects are high and the address is 0.
- R10: A write while busy changes nothing on the pins or in the running sequence, and it sets the overrun flag.
- R11: Codes 3'b110 and 3'b111 issue nothing, leave busy low and set the error flag.
- R12: A flag write with bit 0 = 0 clears the error flag and with bit 1 = 0 clears the overrun flag. A 1 keeps the flag. A flag set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SDRAM-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | One-cycle strobe that writes cmd_word |
| cmd_word | input | 32 | Command word (code, selects, refresh count, mode content) |
| flag_wr | input | 1 | Strobe for the flag-clear write |
| flag_wdata | input | 2 | Bit 0 keeps/clears error, bit 1 keeps/clears overrun |
| lmr_gap | input | 4 | Gap code after a mode-register load (code+1 cycles) |
| srx_gap | input | 4 | Gap code after self-refresh exit (code+1 cycles) |
| sd_cke | output | 1 | Clock enable to the devices |
| sd_cs_n | output | 2 | Per-device chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address bus |
| sd_ba | output | 2 | Bank select |
| busy | output | 1 | Sequence or gap in progress |
| err_flag | output | 1 | Sticky: rejected command |
| ovr_flag | output | 1 | Sticky: command written while busy |

## Verification
The refresh burst is tried with counts of 1, 4 and 15. These show whether the count is off by one and whether the inter-refresh NOP gap is applied after every refresh, the last one included. The mode-load gap is tried at codes 0 and 15, and the self-refresh exit at a mid code, to separate the code+1 rule from a plain code or a fixed delay. Device selects are tried as device 0 alone, device 1 alone, both and neither, which catches swapped or inverted selects. Writes while busy, reserved codes and the reserved count are interleaved with flag clears to show that the rejected paths leave the pins and the running sequence untouched.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int NDEV   = 2;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;
  localparam int MRC_W  = 13;
  localparam int SEL_LSB = 3;
  localparam int CNT_LSB = 5;
  localparam int MRC_LSB = 9;

  typedef enum logic [CODE_W-1:0] {
    OP_NORMAL = 3'b000,
    OP_CKE_ON = 3'b001,
    OP_PALL   = 3'b010,
    OP_AREF   = 3'b011,
    OP_LMR    = 3'b100,
    OP_SREF   = 3'b101,
    OP_RSV6   = 3'b110,
    OP_RSV7   = 3'b111
  } op_e;

  // pin pattern presented in a given cycle
  typedef enum logic [2:0] {
    PIN_IDLE,
    PIN_NOP,
    PIN_PRE,
    PIN_REF,
    PIN_LMR
  } pin_e;

  typedef struct packed {
    op_e              op;
    logic [NDEV-1:0]  sel;
    logic [CNT_W-1:0] cnt;
    logic [MRC_W-1:0] mrc;
  } cmd_s;

  function automatic cmd_s split_word(input logic [31:0] w);
    cmd_s c;
    c.op  = op_e'(w[CODE_W-1:0]);
    c.sel = w[SEL_LSB +: NDEV];
    c.cnt = w[CNT_LSB +: CNT_W];
    c.mrc = w[MRC_LSB +: MRC_W];
    return c;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_seq_pkg::*;
#(
  parameter int RFC_GAP = 2,
  parameter int GAP_CW  = 5
) (
  input  op_e               op,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              sr_active,
  input  logic [3:0]        lmr_gap,
  input  logic [3:0]        srx_gap,
  output logic              legal,
  output pin_e              first_pin,
  output logic [CNT_W-1:0]  more_refs,
  output logic [GAP_CW-1:0] post_gap,
  output logic              cke_set,
  output logic              cke_clr
);

  localparam logic [CNT_W-1:0] CNT_RSV = '1;

  always_comb begin
    legal     = 1'b1;
    first_pin = PIN_NOP;
    more_refs = '0;
    post_gap  = '0;
    cke_set   = 1'b0;
    cke_clr   = 1'b0;
    unique case (op)
      OP_NORMAL: first_pin = PIN_NOP;
      OP_CKE_ON: begin
        cke_set = 1'b1;
        if (sr_active) post_gap = GAP_CW'(srx_gap) + GAP_CW'(1);
      end
      OP_PALL: first_pin = PIN_PRE;
      OP_AREF: begin
        if (cnt == CNT_RSV) begin
          legal = 1'b0;
        end else begin
          first_pin = PIN_REF;
          more_refs = cnt;
          post_gap  = GAP_CW'(RFC_GAP);
        end
      end
      OP_LMR: begin
        first_pin = PIN_LMR;
        post_gap  = GAP_CW'(lmr_gap) + GAP_CW'(1);
      end
      OP_SREF: begin
        first_pin = PIN_REF;
        cke_clr   = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int RFC_GAP = 2,
  parameter int GAP_CW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  pin_e              dec_pin,
  input  logic [CNT_W-1:0]  dec_refs,
  input  logic [GAP_CW-1:0] dec_gap,
  input  logic              dec_cke_set,
  input  logic              dec_cke_clr,
  input  logic [NDEV-1:0]   sel_in,
  input  logic [MRC_W-1:0]  mrc_in,
  output logic              busy_q,
  output logic              cke_q,
  output logic              sr_q,
  output pin_e              pin_nxt,
  output logic [NDEV-1:0]   sel_nxt,
  output logic [MRC_W-1:0]  mrc_nxt
);

  logic [GAP_CW-1:0] gap_q;
  logic [CNT_W-1:0]  refs_q;
  logic [NDEV-1:0]   sel_q;
  logic [MRC_W-1:0]  mrc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      gap_q  <= '0;
      refs_q <= '0;
      sel_q  <= '0;
      mrc_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      gap_q  <= dec_gap;
      refs_q <= dec_refs;
      sel_q  <= sel_in;
      mrc_q  <= mrc_in;
    end else if (busy_q) begin
      if (gap_q != '0) begin
        gap_q <= gap_q - GAP_CW'(1);
      end else if (refs_q != '0) begin
        refs_q <= refs_q - CNT_W'(1);
        gap_q  <= GAP_CW'(RFC_GAP);
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  // clock enable and self-refresh tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q <= 1'b0;
      sr_q  <= 1'b0;
    end else if (start) begin
      if (dec_cke_set) begin
        cke_q <= 1'b1;
        sr_q  <= 1'b0;
      end else if (dec_cke_clr) begin
        cke_q <= 1'b0;
        sr_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    pin_nxt = PIN_IDLE;
    if (start)               pin_nxt = dec_pin;
    else if (busy_q) begin
      if (gap_q != '0)       pin_nxt = PIN_NOP;
      else if (refs_q != '0) pin_nxt = PIN_REF;
      else                   pin_nxt = PIN_IDLE;
    end
  end

  assign sel_nxt = start ? sel_in : sel_q;
  assign mrc_nxt = start ? mrc_in : mrc_q;

  AST_GAP_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (gap_q == '0 || $past(start))) else $error("gap pending while idle"); // R9

endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_e              pin_nxt,
  input  logic [NDEV-1:0]   sel_nxt,
  input  logic [MRC_W-1:0]  mrc_nxt,
  output logic [NDEV-1:0]   cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  // one chip-select register per device
  for (genvar d = 0; d < NDEV; d++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)                      cs_n[d] <= 1'b1;
      else if (pin_nxt == PIN_IDLE) cs_n[d] <= 1'b1;
      else                          cs_n[d] <= ~sel_nxt[d];
    end
  end

  logic [2:0]        strobes_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    strobes_d = 3'b111;
    addr_d    = '0;
    unique case (pin_nxt)
      PIN_PRE: begin strobes_d = 3'b010; addr_d = AP_MASK; end
      PIN_REF: strobes_d = 3'b001;
      PIN_LMR: begin strobes_d = 3'b000; addr_d = ADDR_W'(mrc_nxt); end
      default: strobes_d = 3'b111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {ras_n, cas_n, we_n} <= 3'b111;
      addr <= '0;
      ba   <= '0;
    end else begin
      {ras_n, cas_n, we_n} <= strobes_d;
      addr <= addr_d;
      ba   <= '0;
    end
  end

  AST_PRE_AP: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && cas_n && !we_n) |-> addr[AP_BIT]) else $error("precharge without A10"); // R2

  AST_LMR_BANK0: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && !cas_n && !we_n) |-> (ba == '0)) else $error("mode load bank"); // R6

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int RFC_GAP = 2,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int AP_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic              flag_wr,
  input  logic [1:0]        flag_wdata,
  input  logic [3:0]        lmr_gap,
  input  logic [3:0]        srx_gap,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              busy,
  output logic              err_flag,
  output logic              ovr_flag
);

  localparam int GAP_MAX = (RFC_GAP > 16) ? RFC_GAP : 16;
  localparam int GAP_CW  = $clog2(GAP_MAX + 1);

  cmd_s              cmd;
  logic              rsvd_unused;
  logic              legal;
  pin_e              dec_pin;
  logic [CNT_W-1:0]  dec_refs;
  logic [GAP_CW-1:0] dec_gap;
  logic              dec_cke_set, dec_cke_clr;
  logic              sr_q;
  logic              start;
  pin_e              pin_nxt;
  logic [NDEV-1:0]   sel_nxt;
  logic [MRC_W-1:0]  mrc_nxt;

  assign cmd         = split_word(cmd_word);
  assign rsvd_unused = ^cmd_word[31:22];

  sdram_cmd_decode #(.RFC_GAP(RFC_GAP), .GAP_CW(GAP_CW)) u_dec (
    .op(cmd.op), .cnt(cmd.cnt), .sr_active(sr_q),
    .lmr_gap(lmr_gap), .srx_gap(srx_gap),
    .legal(legal), .first_pin(dec_pin), .more_refs(dec_refs),
    .post_gap(dec_gap), .cke_set(dec_cke_set), .cke_clr(dec_cke_clr)
  );

  assign start = cmd_wr && !busy && legal;

  sdram_seq_ctrl #(.RFC_GAP(RFC_GAP), .GAP_CW(GAP_CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dec_pin(dec_pin), .dec_refs(dec_refs), .dec_gap(dec_gap),
    .dec_cke_set(dec_cke_set), .dec_cke_clr(dec_cke_clr),
    .sel_in(cmd.sel), .mrc_in(cmd.mrc),
    .busy_q(busy), .cke_q(sd_cke), .sr_q(sr_q),
    .pin_nxt(pin_nxt), .sel_nxt(sel_nxt), .mrc_nxt(mrc_nxt)
  );

  sdram_pin_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_pins (
    .clk(clk), .rst(rst), .pin_nxt(pin_nxt), .sel_nxt(sel_nxt), .mrc_nxt(mrc_nxt),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr), .ba(sd_ba)
  );

  // sticky flags: a set in the same cycle wins over a clear
  logic err_d, ovr_d;
  always_comb begin
    err_d = flag_wr ? (err_flag & flag_wdata[0]) : err_flag;
    ovr_d = flag_wr ? (ovr_flag & flag_wdata[1]) : ovr_flag;
    if (cmd_wr && !busy && !legal) err_d = 1'b1;
    if (cmd_wr && busy)            ovr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      err_flag <= err_d;
      ovr_flag <= ovr_d;
    end
  end

  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (sd_cs_n != '1) |-> busy) else $error("select outside busy"); // R9

  AST_OVR_ON_BUSY_WR: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> ovr_flag) else $error("overrun not flagged"); // R10

  AST_BAD_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && cmd.op == OP_AREF && cmd.cnt == '1) |=> (!busy && err_flag))
    else $error("reserved count accepted"); // R5

  AST_RSV_CODE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && (cmd.op == OP_RSV6 || cmd.op == OP_RSV7)) |=> (!busy && err_flag))
    else $error("reserved code accepted"); // R11

  AST_SREF_CKE_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_cke) |-> (!sd_ras_n && !sd_cas_n && sd_we_n)) else $error("cke fell without refresh"); // R7

  AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_cke) |-> (sd_ras_n && sd_cas_n && sd_we_n)) else $error("cke rose with command"); // R3

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  localparam int RFC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        flag_wr = 1'b0;
  logic [1:0]  flag_wdata = 2'b11;
  logic [3:0]  lmr_gap = 4'd0;
  logic [3:0]  srx_gap = 4'd0;
  logic        sd_cke, sd_ras_n, sd_cas_n, sd_we_n, busy, err_flag, ovr_flag;
  logic [1:0]  sd_cs_n, sd_ba;
  logic [12:0] sd_addr;

  always #5 clk = ~clk;

  sdram_init_seq #(.RFC_GAP(RFC)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .lmr_gap(lmr_gap), .srx_gap(srx_gap),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .busy(busy), .err_flag(err_flag), .ovr_flag(ovr_flag)
  );

  typedef struct packed {
    logic [1:0]  cs;
    logic        ras, cas, we;
    logic [12:0] addr;
    logic        cke;
    logic        bsy;
  } pins_t;

  pins_t  exp_q[$];
  logic   m_cke = 1'b0, m_sr = 1'b0, m_err = 1'b0, m_ovr = 1'b0, cur_busy = 1'b0;
  int     n_chk = 0, n_err = 0;
  string  cur_req = "R1";
  bit     done = 0;

  // kind: 0 NOP, 1 precharge, 2 refresh, 3 mode load
  function automatic pins_t mk(input int kind, input logic [1:0] sel, input logic [12:0] a);
    pins_t p;
    p.cs = ~sel; p.addr = 13'd0; p.cke = m_cke; p.bsy = 1'b1;
    case (kind)
      1: begin {p.ras, p.cas, p.we} = 3'b010; p.addr = 13'h400; end
      2: {p.ras, p.cas, p.we} = 3'b001;
      3: begin {p.ras, p.cas, p.we} = 3'b000; p.addr = a; end
      default: {p.ras, p.cas, p.we} = 3'b111;
    endcase
    return p;
  endfunction

  function automatic logic [31:0] w(input logic [2:0] code, input logic [1:0] sel,
                                    input logic [3:0] cnt, input logic [12:0] mrc);
    return {10'b0, mrc, cnt, sel[1], sel[0], code};
  endfunction

  task automatic check();
    pins_t e, a;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin
      e = '0; e.cs = 2'b11; {e.ras, e.cas, e.we} = 3'b111; e.cke = m_cke; e.bsy = 1'b0;
    end
    a = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_cke, busy};
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s pins{cs,ras,cas,we,addr,cke,busy} actual=%h expected=%h", cur_req, a, e);
    end
    n_chk++;
    if ({err_flag, ovr_flag, sd_ba} !== {m_err, m_ovr, 2'b00}) begin
      n_err++;
      $display("FAIL %s flags{err,ovr,ba} actual=%b expected=%b", cur_req,
               {err_flag, ovr_flag, sd_ba}, {m_err, m_ovr, 2'b00});
    end
    cur_busy = e.bsy;
  endtask

  task automatic model_apply();
    logic [2:0]  code;
    logic [1:0]  sel;
    logic [3:0]  cnt;
    logic [12:0] mrc;
    if (flag_wr) begin
      m_err = m_err & flag_wdata[0];
      m_ovr = m_ovr & flag_wdata[1];
    end
    if (cmd_wr) begin
      code = cmd_word[2:0]; sel = cmd_word[4:3]; cnt = cmd_word[8:5]; mrc = cmd_word[21:9];
      if (cur_busy) m_ovr = 1'b1;
      else begin
        case (code)
          3'd0: exp_q.push_back(mk(0, sel, 0));
          3'd1: begin
            m_cke = 1'b1;
            exp_q.push_back(mk(0, sel, 0));
            if (m_sr) for (int i = 0; i <= int'(srx_gap); i++) exp_q.push_back(mk(0, sel, 0));
            m_sr = 1'b0;
          end
          3'd2: exp_q.push_back(mk(1, sel, 0));
          3'd3: begin
            if (cnt == 4'hF) m_err = 1'b1;
            else for (int r = 0; r <= int'(cnt); r++) begin
              exp_q.push_back(mk(2, sel, 0));
              for (int g = 0; g < RFC; g++) exp_q.push_back(mk(0, sel, 0));
            end
          end
          3'd4: begin
            exp_q.push_back(mk(3, sel, mrc));
            for (int g = 0; g <= int'(lmr_gap); g++) exp_q.push_back(mk(0, sel, 0));
          end
          3'd5: begin m_cke = 1'b0; m_sr = 1'b1; exp_q.push_back(mk(2, sel, 0)); end
          default: m_err = 1'b1;
        endcase
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    check();
    model_apply();
    @(posedge clk);
    #1;
    cmd_wr  = 1'b0;
    flag_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] word);
    cmd_wr = 1'b1; cmd_word = word;
    cycle();
  endtask

  task automatic clear_flags(input logic [1:0] keep);
    flag_wr = 1'b1; flag_wdata = keep;
    cycle();
  endtask

  task automatic drain();
    while (exp_q.size() > 0) cycle();
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cur_req = "R1"; repeat (2) cycle();

    cur_req = "R3";  send(w(3'b001, 2'b11, 0, 0)); drain();
    send(w(3'b000, 2'b11, 0, 0)); drain();
    cur_req = "R2";  send(w(3'b010, 2'b11, 0, 0)); drain();
    cur_req = "R8";  send(w(3'b010, 2'b01, 0, 0)); drain();
    send(w(3'b010, 2'b10, 0, 0)); drain();
    send(w(3'b011, 2'b00, 4'd1, 0)); drain();
    cur_req = "R4";  send(w(3'b011, 2'b11, 4'd0, 0)); drain();
    send(w(3'b011, 2'b01, 4'd3, 0)); drain();
    send(w(3'b011, 2'b11, 4'd14, 0)); drain();
    cur_req = "R5";  send(w(3'b011, 2'b11, 4'hF, 0)); repeat (2) cycle();
    cur_req = "R12"; clear_flags(2'b10); cycle();
    cur_req = "R6";  lmr_gap = 4'd0; send(w(3'b100, 2'b11, 0, 13'h1A5C)); drain();
    lmr_gap = 4'd15; send(w(3'b100, 2'b10, 4'd7, 13'h0033)); drain();
    cur_req = "R11"; send(w(3'b110, 2'b11, 0, 0)); cycle();
    send(w(3'b111, 2'b01, 0, 0)); cycle();
    cur_req = "R10"; send(w(3'b011, 2'b11, 4'd3, 0)); cycle();
    send(w(3'b100, 2'b11, 0, 13'h1FFF)); cycle();
    cur_req = "R12"; flag_wr = 1'b1; flag_wdata = 2'b00; cmd_wr = 1'b1;
    cmd_word = w(3'b010, 2'b11, 0, 0); cycle();
    drain();
    clear_flags(2'b01); cycle();
    clear_flags(2'b10); cycle();
    cur_req = "R7";  srx_gap = 4'd5; send(w(3'b101, 2'b11, 0, 0)); drain();
    send(w(3'b000, 2'b01, 0, 0)); drain();
    send(w(3'b001, 2'b11, 0, 0)); drain();
    cur_req = "R3";  send(w(3'b001, 2'b10, 0, 0)); drain();
    cur_req = "R9";  repeat (3) cycle();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule